// File: doc/BRIEF.md
# Packet-Committed Ring Buffer for a Receive Endpoint

This block holds received packets between a fast serial bus and a slower local I/O interface. Its storage is one dual-port RAM split into a small ring of slots. Each slot holds one packet of up to 512 bytes, kept as 256 words of 16 bits. A bus-side writer streams words into the slot it currently owns. When the packet ends, the writer raises a commit strobe if the packet checked good, or a discard strobe if it did not. A discarded packet is dropped without disturbing the slots already committed. A committed slot is handed to the I/O side only when it is complete.

The I/O side reads committed data as an ordinary first-word-fall-through stream FIFO. It has an empty flag, a full flag and a level flag set by a threshold. It can read whole 16-bit words, or single bytes with the low byte first. The reader never sees slot boundaries. It stops at each packet's recorded byte length and then frees the slot.

The two sides run on unrelated clocks. Slot ownership crosses between them as gray-coded packet counters, each passed through two flops. The ring can hold two, three or four slots, chosen by a configuration input that may change only while reset is held.

Top module: `pkt_ring_fifo`

## Requirements
- R1: Words written into a slot stay invisible to the reader (`rd_empty` stays 1) until `wr_commit` is raised for that packet. After the commit, the words come out in the order they were written. A word written in the same cycle as a strobe belongs to the packet.
- R2: `wr_discard` throws away the slot being filled. Packets committed earlier, and packets committed afterwards, are read back unchanged.
- R3: `cfg_slots` sets the number of slots: 0 gives 2, 1 gives 3, and 2 or 3 give 4. `wr_full` is 1 when no slot is free beyond the one being filled, meaning all slots are committed, or all but one are committed and the remaining one holds at least one word. `rd_full` is 1 when every slot is committed and unread, as seen by the reader.
- R4: `rd_empty` is 1 when no committed data is unread. While empty, `rd_data` is 0 and `rd_en` has no effect.
- R5: With `rd_byte_mode` = 1, each read delivers one byte in `rd_data[7:0]`, low byte of the word first, with `rd_data[15:8]` = 0.
- R6: A commit with `wr_odd` = 1 records the length as twice the word count minus one. In word mode, the last word of such a packet is delivered with its upper byte forced to 0. After the final byte of a packet, the reader moves on to the next slot.
- R7: A write when every slot is committed, or a 257th word into one slot, raises `wr_ovf`. The word is dropped, and that packet is discarded even if it is later committed. `wr_ovf` stays 1 until reset.
- R8: `rd_prog` is 1 when the unread amount, counted in words (unread bytes divided by two, rounded up), is at or below `rd_thresh`. The threshold is registered in the read clock domain, so a change takes effect one read clock later.
- R9: After the asynchronous active-low `rst_n`, both sides are empty: `rd_empty` = 1, `wr_full` = 0, `rd_full` = 0, `wr_ovf` = 0.
- R10: A commit of a packet with no words is treated as a discard.
- R11: When `wr_commit` and `wr_discard` are raised in the same cycle, the discard wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Bus-side clock |
| rd_clk | input | 1 | I/O-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_slots | input | 2 | Slot count select (0:2, 1:3, 2/3:4) |
| wr_en | input | 1 | Write one word into the current slot |
| wr_data | input | 16 | Word to write |
| wr_commit | input | 1 | End of packet, checked good |
| wr_discard | input | 1 | End of packet, checked bad |
| wr_odd | input | 1 | With commit: last word carries only its low byte |
| wr_full | output | 1 | No slot free beyond the one being filled |
| wr_ovf | output | 1 | Sticky overflow error |
| rd_en | input | 1 | Consume the word or byte shown on rd_data |
| rd_byte_mode | input | 1 | 1: byte reads, 0: word reads |
| rd_thresh | input | 11 | Level threshold in words |
| rd_data | output | 16 | Head word or byte |
| rd_empty | output | 1 | No committed data unread |
| rd_full | output | 1 | All slots committed and unread |
| rd_prog | output | 1 | Unread words at or below threshold |

## Verification
The hardest state to reach from the ports is a ring in which every configured slot is committed while the reader stays idle, followed by a write that must be dropped. The bench holds `rd_en` low, commits exactly as many packets as the configured slot count, and waits for both flags to settle across the clock boundary. It then writes one more word, commits it, and drains the ring to show that the dropped word never appears. The 257-word overflow and the boundary between a full and a not-quite-full ring (the last free slot partly filled) are reached the same way, by timing the strobes carefully while the reader is stalled.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int DATA_W     = 16;
  localparam int SLOT_WORDS = 256;
  localparam int MAX_SLOTS  = 4;

  localparam int WORD_AW = $clog2(SLOT_WORDS);
  localparam int IDX_W   = $clog2(MAX_SLOTS);
  localparam int CNT_W   = IDX_W + 1;
  localparam int RAM_AW  = IDX_W + WORD_AW;
  localparam int LEN_W   = $clog2(SLOT_WORDS * 2) + 1;
  localparam int BYTES_W = $clog2(SLOT_WORDS * 2 * MAX_SLOTS) + 1;
  localparam int LVL_W   = $clog2(SLOT_WORDS * MAX_SLOTS) + 1;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [WORD_AW:0]   fill_t;
  typedef logic [LEN_W-1:0]   len_t;
  typedef logic [BYTES_W-1:0] bytes_t;
  typedef logic [LVL_W-1:0]   lvl_t;
  typedef logic [MAX_SLOTS-1:0][LEN_W-1:0] len_arr_t;

  function automatic cnt_t bin2gray(cnt_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic cnt_t gray2bin(cnt_t g);
    cnt_t b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // configuration code to number of ring slots
  function automatic cnt_t slots_of_cfg(logic [1:0] c);
    case (c)
      2'd0:    return cnt_t'(2);
      2'd1:    return cnt_t'(3);
      default: return cnt_t'(MAX_SLOTS);
    endcase
  endfunction

  // slot index k places after i, wrapping at n
  function automatic idx_t idx_plus(idx_t i, cnt_t k, cnt_t n);
    cnt_t s;
    s = cnt_t'(i) + k;
    if (s >= n) s = s - n;
    return idx_t'(s);
  endfunction

  function automatic len_t byte_len(fill_t words, logic odd);
    len_t l;
    l = len_t'(words) << 1;
    return l - len_t'(odd);
  endfunction

  function automatic lvl_t words_of_bytes(bytes_t b);
    return lvl_t'((b + bytes_t'(1)) >> 1);
  endfunction
endpackage

// File: rtl/prf_sync.sv
module prf_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/prf_ram.sv
module prf_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/prf_wr_ctl.sv
module prf_wr_ctl
  import prf_pkg::*;
(
  input  logic              wr_clk,
  input  logic              rst_n,
  input  cnt_t              n_slots,
  input  logic              wr_en,
  input  logic              wr_commit,
  input  logic              wr_discard,
  input  logic              wr_odd,
  input  cnt_t              rd_gray_s,
  output cnt_t              wr_gray,
  output logic              mem_we,
  output logic [RAM_AW-1:0] mem_waddr,
  output len_arr_t          lens,
  output logic              wr_full,
  output logic              wr_ovf
);
  localparam fill_t FILL_MAX = fill_t'(SLOT_WORDS);

  cnt_t  wr_cnt, occ;
  idx_t  wr_idx;
  fill_t fill, fill_n;
  logic  bad, no_slot, room, ovf_evt, keep_evt, pkt_end;

  // named events for the assertions below
  always_comb begin
    occ      = wr_cnt - gray2bin(rd_gray_s);
    no_slot  = (occ >= n_slots);
    room     = (fill < FILL_MAX);
    mem_we   = wr_en && !bad && !no_slot && room;
    ovf_evt  = wr_en && !bad && (no_slot || !room);
    fill_n   = fill + fill_t'(mem_we);
    pkt_end  = wr_commit || wr_discard;
    keep_evt = wr_commit && !wr_discard && !bad && !ovf_evt && (fill_n != '0);
    wr_full  = no_slot || (((occ + cnt_t'(1)) == n_slots) && (fill != '0));
  end

  assign mem_waddr = {wr_idx, fill[WORD_AW-1:0]};

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt  <= '0;
      wr_gray <= '0;
      wr_idx  <= '0;
      fill    <= '0;
      bad     <= 1'b0;
      wr_ovf  <= 1'b0;
      lens    <= '0;
    end else begin
      wr_ovf <= wr_ovf | ovf_evt;
      if (pkt_end) begin
        fill <= '0;
        bad  <= 1'b0;
      end else begin
        fill <= fill_n;
        bad  <= bad | ovf_evt;
      end
      if (keep_evt) begin
        lens[wr_idx] <= byte_len(fill_n, wr_odd);
        wr_cnt       <= wr_cnt + cnt_t'(1);
        wr_gray      <= bin2gray(wr_cnt + cnt_t'(1));
        wr_idx       <= idx_plus(wr_idx, cnt_t'(1), n_slots);
      end
    end
  end

  AST_OCC_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
    occ <= n_slots); // R3
  AST_DISCARD_NO_HANDOFF: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_discard |=> $stable(wr_gray)); // R2
  AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_ovf |=> wr_ovf); // R7
  AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1); // R1
endmodule

// File: rtl/prf_rd_ctl.sv
module prf_rd_ctl
  import prf_pkg::*;
(
  input  logic              rd_clk,
  input  logic              rst_n,
  input  cnt_t              n_slots,
  input  logic              rd_en,
  input  logic              rd_byte_mode,
  input  lvl_t              rd_thresh,
  input  cnt_t              wr_gray_s,
  input  len_arr_t          lens,
  input  logic [DATA_W-1:0] mem_rdata,
  output cnt_t              rd_gray,
  output logic [RAM_AW-1:0] mem_raddr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_full,
  output logic              rd_prog
);
  localparam int HALF = DATA_W / 2;

  cnt_t   rd_cnt, avail;
  idx_t   rd_idx;
  len_t   ofs, head_len, step_to;
  logic   pop, slot_done, last_single;
  bytes_t pend;
  lvl_t   words, thresh_q;

  always_comb begin
    avail       = gray2bin(wr_gray_s) - rd_cnt;
    rd_empty    = (avail == '0);
    rd_full     = (avail == n_slots);
    head_len    = lens[rd_idx];
    pop         = rd_en && !rd_empty;
    step_to     = rd_byte_mode ? (ofs + len_t'(1)) : ((ofs | len_t'(1)) + len_t'(1));
    slot_done   = (step_to >= head_len);
    last_single = ((ofs + len_t'(1)) == head_len);
  end

  // unread bytes summed over committed slots, minus what the head has used
  always_comb begin
    pend = '0;
    for (int k = 0; k < MAX_SLOTS; k++) begin
      if (cnt_t'(k) < avail)
        pend = pend + bytes_t'(lens[idx_plus(rd_idx, cnt_t'(k), n_slots)]);
    end
    pend    = pend - bytes_t'(ofs);
    words   = words_of_bytes(pend);
    rd_prog = (words <= thresh_q);
  end

  assign mem_raddr = {rd_idx, ofs[WORD_AW:1]};

  always_comb begin
    if (rd_empty)
      rd_data = '0;
    else if (ofs[0])
      rd_data = {{HALF{1'b0}}, mem_rdata[DATA_W-1:HALF]};
    else if (rd_byte_mode || last_single)
      rd_data = {{HALF{1'b0}}, mem_rdata[HALF-1:0]};
    else
      rd_data = mem_rdata;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt   <= '0;
      rd_gray  <= '0;
      rd_idx   <= '0;
      ofs      <= '0;
      thresh_q <= '0;
    end else begin
      thresh_q <= rd_thresh;
      if (pop) begin
        if (slot_done) begin
          ofs     <= '0;
          rd_cnt  <= rd_cnt + cnt_t'(1);
          rd_gray <= bin2gray(rd_cnt + cnt_t'(1));
          rd_idx  <= idx_plus(rd_idx, cnt_t'(1), n_slots);
        end else begin
          ofs <= step_to;
        end
      end
    end
  end

  AST_EMPTY_HOLDS: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |=> $stable(rd_gray)); // R4
  AST_AVAIL_BOUND: assert property (@(posedge rd_clk) disable iff (!rst_n)
    avail <= n_slots); // R3
  AST_OFS_IN_SLOT: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_empty |-> (ofs < head_len)); // R6
  AST_EMPTY_LEVEL: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |-> rd_prog); // R8
  AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1); // R4
endmodule

// File: rtl/pkt_ring_fifo.sv
module pkt_ring_fifo
  import prf_pkg::*;
(
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_slots,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_commit,
  input  logic              wr_discard,
  input  logic              wr_odd,
  output logic              wr_full,
  output logic              wr_ovf,
  input  logic              rd_en,
  input  logic              rd_byte_mode,
  input  logic [LVL_W-1:0]  rd_thresh,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  output logic              rd_full,
  output logic              rd_prog
);
  cnt_t              n_slots;
  cnt_t              wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  logic              mem_we;
  logic [RAM_AW-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  len_arr_t          lens;

  assign n_slots = slots_of_cfg(cfg_slots);

  prf_sync #(.W(CNT_W)) i_sync_to_rd (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s));

  prf_sync #(.W(CNT_W)) i_sync_to_wr (
    .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s));

  prf_ram #(.WIDTH(DATA_W), .DEPTH(MAX_SLOTS * SLOT_WORDS)) i_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata));

  prf_wr_ctl i_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .n_slots(n_slots),
    .wr_en(wr_en), .wr_commit(wr_commit), .wr_discard(wr_discard), .wr_odd(wr_odd),
    .rd_gray_s(rd_gray_s), .wr_gray(wr_gray),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .lens(lens),
    .wr_full(wr_full), .wr_ovf(wr_ovf));

  prf_rd_ctl i_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .n_slots(n_slots),
    .rd_en(rd_en), .rd_byte_mode(rd_byte_mode), .rd_thresh(rd_thresh),
    .wr_gray_s(wr_gray_s), .lens(lens), .mem_rdata(mem_rdata),
    .rd_gray(rd_gray), .mem_raddr(mem_raddr), .rd_data(rd_data),
    .rd_empty(rd_empty), .rd_full(rd_full), .rd_prog(rd_prog));
endmodule

// File: tb/test_pkt_ring_fifo.sv
`timescale 1ns/1ps
module test_pkt_ring_fifo;
  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        rst_n  = 1'b0;
  logic [1:0]  cfg_slots = 2'd2;
  logic        wr_en = 1'b0, wr_commit = 1'b0, wr_discard = 1'b0, wr_odd = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0, rd_byte_mode = 1'b0;
  logic [10:0] rd_thresh = '0;
  logic [15:0] rd_data;
  logic        wr_full, wr_ovf, rd_empty, rd_full, rd_prog;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 wr_clk = ~wr_clk;   // 125 MHz bus side
  always #5 rd_clk = ~rd_clk;   // 100 MHz I/O side

  pkt_ring_fifo i_pkt_ring_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_slots(cfg_slots),
    .wr_en(wr_en), .wr_data(wr_data), .wr_commit(wr_commit), .wr_discard(wr_discard),
    .wr_odd(wr_odd), .wr_full(wr_full), .wr_ovf(wr_ovf),
    .rd_en(rd_en), .rd_byte_mode(rd_byte_mode), .rd_thresh(rd_thresh),
    .rd_data(rd_data), .rd_empty(rd_empty), .rd_full(rd_full), .rd_prog(rd_prog));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] cfg);
    rst_n = 1'b0;
    cfg_slots = cfg;
    wr_en = 0; wr_commit = 0; wr_discard = 0; wr_odd = 0; rd_en = 0; rd_byte_mode = 0;
    repeat (3) @(negedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic push_words(input logic [15:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1'b1;
      wr_data = base + 16'(i);
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input logic c, input logic d, input logic odd);
    @(negedge wr_clk);
    wr_commit = c; wr_discard = d; wr_odd = odd;
    @(negedge wr_clk);
    wr_commit = 0; wr_discard = 0; wr_odd = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic pop(input string req, input logic [15:0] exp);
    @(negedge rd_clk);
    chk(req, rd_data, exp);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic pop_run(input string req, input logic [15:0] base, input int n);
    for (int i = 0; i < n; i++) pop(req, base + 16'(i));
  endtask

  task automatic t_reset();
    do_reset(2'd2);
    chk("R9 empty", rd_empty, 1);
    chk("R9 wr_full", wr_full, 0);
    chk("R9 rd_full", rd_full, 0);
    chk("R9 ovf", wr_ovf, 0);
    chk("R4 data zero when empty", rd_data, 0);
  endtask

  task automatic t_hidden_until_commit();
    push_words(16'h1100, 4);
    settle();
    chk("R1 hidden before commit", rd_empty, 1);
    strobe(1, 0, 0);
    settle();
    chk("R1 visible after commit", rd_empty, 0);
    pop_run("R1 order", 16'h1100, 4);
    chk("R1 empty after packet", rd_empty, 1);
  endtask

  task automatic t_discard();
    push_words(16'h1000, 2); strobe(1, 0, 0);
    push_words(16'h2000, 3); strobe(0, 1, 0);
    push_words(16'h2500, 2); strobe(1, 1, 0);   // R11 both strobes
    push_words(16'h3000, 2); strobe(1, 0, 0);
    settle();
    pop_run("R2 earlier kept", 16'h1000, 2);
    pop_run("R2 R11 next good packet", 16'h3000, 2);
    chk("R11 nothing else", rd_empty, 1);
  endtask

  task automatic t_odd();
    push_words(16'hA1B0, 3);
    strobe(1, 0, 1);
    settle();
    pop("R6 odd w0", 16'hA1B0);
    pop("R6 odd w1", 16'hA1B1);
    pop("R6 odd last byte", 16'h00B2);
    chk("R6 released at length", rd_empty, 1);
  endtask

  task automatic t_bytes();
    @(negedge wr_clk); wr_en = 1; wr_data = 16'h1234;
    @(negedge wr_clk); wr_data = 16'h5678;
    @(negedge wr_clk); wr_en = 0;
    strobe(1, 0, 0);
    settle();
    rd_byte_mode = 1'b1;
    pop("R5 byte 0", 16'h0034);
    pop("R5 byte 1", 16'h0012);
    pop("R5 byte 2", 16'h0078);
    pop("R5 byte 3", 16'h0056);
    chk("R5 empty", rd_empty, 1);
    rd_byte_mode = 1'b0;
  endtask

  task automatic t_full_two();
    do_reset(2'd0);
    push_words(16'h0A00, 1); strobe(1, 0, 0);
    chk("R3 one of two", wr_full, 0);
    push_words(16'h0B00, 1); strobe(1, 0, 0);
    chk("R3 wr_full two slots", wr_full, 1);
    settle();
    chk("R3 rd_full two slots", rd_full, 1);
    push_words(16'h0C00, 1); strobe(1, 0, 0);
    chk("R7 ovf on full", wr_ovf, 1);
    pop("R7 A intact", 16'h0A00);
    pop("R7 B intact", 16'h0B00);
    chk("R7 dropped word absent", rd_empty, 1);
    repeat (8) @(negedge wr_clk);
    chk("R3 wr_full clears", wr_full, 0);
    chk("R7 ovf sticky", wr_ovf, 1);
  endtask

  task automatic t_full_three();
    do_reset(2'd1);
    push_words(16'h4000, 1); strobe(1, 0, 0);
    push_words(16'h4100, 1); strobe(1, 0, 0);
    chk("R3 two of three", wr_full, 0);
    push_words(16'h4200, 2);
    chk("R3 last slot filling", wr_full, 1);
    settle();
    chk("R3 rd_full not yet", rd_full, 0);
    strobe(1, 0, 0);
    settle();
    chk("R3 rd_full three", rd_full, 1);
    pop("R3 p0", 16'h4000);
    pop("R3 p1", 16'h4100);
    pop_run("R3 p2", 16'h4200, 2);
    chk("R3 drained", rd_empty, 1);
  endtask

  task automatic t_full_four();
    do_reset(2'd2);
    for (int p = 0; p < 3; p++) begin
      push_words(16'h5000 + 16'(p * 16), 1);
      strobe(1, 0, 0);
    end
    chk("R3 three of four", wr_full, 0);
    push_words(16'h5300, 1);
    chk("R3 four filling", wr_full, 1);
    strobe(0, 1, 0);
    settle();
    for (int p = 0; p < 3; p++) pop("R3 four drain", 16'h5000 + 16'(p * 16));
    chk("R3 four empty", rd_empty, 1);
  endtask

  task automatic t_sizes();
    do_reset(2'd2);
    push_words(16'h0000, 256);
    strobe(1, 0, 0);
    chk("R7 max size no ovf", wr_ovf, 0);
    settle();
    pop_run("R7 max size data", 16'h0000, 256);
    chk("R7 max size released", rd_empty, 1);
    push_words(16'h8000, 257);
    strobe(1, 0, 0);
    chk("R7 overlong ovf", wr_ovf, 1);
    settle();
    chk("R7 overlong dropped", rd_empty, 1);
    strobe(1, 0, 0);
    settle();
    chk("R10 empty commit", rd_empty, 1);
    push_words(16'h9900, 1); strobe(1, 0, 0);
    settle();
    pop("R10 R7 next packet", 16'h9900);
    chk("R10 drained", rd_empty, 1);
  endtask

  task automatic t_prog();
    do_reset(2'd2);
    rd_thresh = 11'd3;
    repeat (2) @(negedge rd_clk);
    chk("R8 empty at level", rd_prog, 1);
    push_words(16'h6000, 5); strobe(1, 0, 0);
    settle();
    chk("R8 five above three", rd_prog, 0);
    pop_run("R8 data", 16'h6000, 2);
    chk("R8 three at three", rd_prog, 1);
    rd_thresh = 11'd1;
    repeat (2) @(negedge rd_clk);
    chk("R8 new threshold", rd_prog, 0);
    pop_run("R8 rest", 16'h6002, 3);
    chk("R8 drained", rd_prog, 1);
  endtask

  task automatic t_empty_pop();
    do_reset(2'd2);
    @(negedge rd_clk); rd_en = 1'b1;
    repeat (4) @(negedge rd_clk);
    rd_en = 1'b0;
    chk("R4 still empty", rd_empty, 1);
    push_words(16'h7700, 2); strobe(1, 0, 0);
    settle();
    pop_run("R4 first word intact", 16'h7700, 2);
    chk("R4 empty again", rd_empty, 1);
  endtask

  initial begin
    t_reset();
    t_hidden_until_commit();
    t_discard();
    t_odd();
    t_bytes();
    t_full_two();
    t_full_three();
    t_full_four();
    t_sizes();
    t_prog();
    t_empty_pop();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule